// File: doc/BRIEF.md
# Frame Key Protection Checker

This block decides whether each memory access may go ahead by comparing the key of the running program against a protection key kept for the addressed page frame. The frame keys sit in a private array that only the set-key and insert-key ports can reach. Ordinary data reads and writes have no path into it. Each frame key holds a 4-bit access-control code and a fetch-guard bit.

A request gives the frame number, whether the access is a fetch or a store, and the current status word. The 4-bit requesting key is taken from a fixed field of that status word. One cycle later the block returns a registered verdict. It either grants the access or refuses it and raises a program-class interruption request. A refused access must not be performed by the surrounding memory path. The data path and address translation lie outside the block.

Top module: `frame_key_guard`

## Requirements
- R1: After reset every frame key reads back as access code 0 with the fetch-guard bit clear, and `rsp_valid`, `rsp_grant` and `pgm_int_req` are all low.
- R2: A cycle with `set_en` high writes `set_acc` and `set_fguard` into the key of frame `set_frame`. From the next cycle on, the insert port (`ins_frame` in, `ins_acc`/`ins_fguard` out, combinational) returns the new value, and every other frame keeps its key.
- R3: The requesting key is the 4-bit field at status-word positions 8 to 11, with positions counted from the most significant bit as position 0. With the default 64-bit word this is `req_status[55:52]`, and `req_status[55]` is the key's most significant bit. No other status bit affects the verdict.
- R4: A request with `req_valid` high in one cycle produces `rsp_valid` high in the next cycle. Requests may arrive back to back.
- R5: A requesting key of zero is granted every fetch and every store, whatever the frame key holds.
- R6: A store with a nonzero requesting key is granted only when that key equals the frame's access code.
- R7: A fetch whose nonzero requesting key differs from the frame's access code is refused when the frame's fetch-guard bit is 1 and granted when it is 0. A fetch with equal keys is granted.
- R8: While `rsp_valid` is high exactly one of `rsp_grant` and `pgm_int_req` is high. `pgm_int_req` marks a refused access.
- R9: When a set-key write and a request to the same frame share a cycle, that request is judged against the old key. A request in the following cycle is judged against the new one.
- R10: In a cycle after which no request was presented, `rsp_valid`, `rsp_grant` and `pgm_int_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_en | input | 1 | Write one frame key this cycle |
| set_frame | input | $clog2(NUM_FRAMES) | Frame whose key is written |
| set_acc | input | 4 | Access code to write |
| set_fguard | input | 1 | Fetch-guard bit to write |
| ins_frame | input | $clog2(NUM_FRAMES) | Frame whose key is read out |
| ins_acc | output | 4 | Access code of `ins_frame` |
| ins_fguard | output | 1 | Fetch-guard bit of `ins_frame` |
| req_valid | input | 1 | Access request present |
| req_frame | input | $clog2(NUM_FRAMES) | Frame addressed by the request |
| req_store | input | 1 | 1 = store, 0 = fetch |
| req_status | input | SW_W | Current status word carrying the requesting key |
| rsp_valid | output | 1 | Verdict present (one cycle after the request) |
| rsp_grant | output | 1 | Access may proceed |
| pgm_int_req | output | 1 | Protection violation, program-class interruption request |

## Verification
The assertions check these rules on every cycle: the one-cycle verdict latency, the exclusivity of grant and violation, the quiet outputs after an idle cycle, a key-zero request always granted, a mismatched store always refused, a fetch to an unguarded frame always granted, and a set-key write landing in the addressed entry. Some behaviour only the bench's directed scenarios can show. This covers which status bits form the key, that other frames keep their keys after a write, and the reset contents of the array. It also covers the ordering when a write and a request to the same frame share a cycle, and the full grant pattern across fetch, store and guard-bit combinations.

// File: rtl/fkg_pkg.sv
package fkg_pkg;

   localparam int ACC_W = 4;

   typedef struct packed {
      logic [ACC_W-1:0] acc;
      logic             fguard;
   } frame_key_t;

   typedef enum logic {
      KIND_FETCH = 1'b0,
      KIND_STORE = 1'b1
   } access_kind_t;

   localparam frame_key_t KEY_RESET = '{acc: '0, fguard: 1'b0};

endpackage

// File: rtl/fkg_key_array.sv
module fkg_key_array
   import fkg_pkg::*;
#(
   parameter int NUM_FRAMES = 64,
   localparam int FRAME_W   = $clog2(NUM_FRAMES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [FRAME_W-1:0] wr_frame,
   input  frame_key_t         wr_key,
   input  logic [FRAME_W-1:0] rd_a_frame,
   output frame_key_t         rd_a_key,
   input  logic [FRAME_W-1:0] rd_b_frame,
   output frame_key_t         rd_b_key
);

   frame_key_t entry_q [NUM_FRAMES];

   for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_entry
      logic hit;
      assign hit = wr_en && (wr_frame == FRAME_W'(f));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   entry_q[f] <= KEY_RESET;
         else if (hit) entry_q[f] <= wr_key;
      end
   end

   assign rd_a_key = entry_q[rd_a_frame];
   assign rd_b_key = entry_q[rd_b_frame];

   // R2: a write is visible in the addressed entry one cycle later
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> entry_q[$past(wr_frame)] == $past(wr_key));

endmodule

// File: rtl/fkg_access_judge.sv
module fkg_access_judge
   import fkg_pkg::*;
#(
   parameter bit MASTER_KEY_EN = 1'b1
) (
   input  logic [ACC_W-1:0] req_key,
   input  access_kind_t     kind,
   input  frame_key_t       fkey,
   output logic             grant
);

   logic key_match;
   logic fetch_ok;
   logic store_ok;
   logic master;

   assign key_match = (req_key == fkey.acc);

   if (MASTER_KEY_EN) begin : g_master
      assign master = (req_key == '0);
   end else begin : g_no_master
      assign master = 1'b0;
   end

   always_comb begin
      fetch_ok = key_match || !fkey.fguard;
      store_ok = key_match;
      unique case (kind)
         KIND_STORE: grant = master || store_ok;
         default:    grant = master || fetch_ok;
      endcase
   end

endmodule

// File: rtl/fkg_resp_stage.sv
module fkg_resp_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_grant,
   output logic out_valid,
   output logic out_grant,
   output logic out_violation
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_grant     <= 1'b0;
         out_violation <= 1'b0;
      end else begin
         out_valid     <= in_valid;
         out_grant     <= in_valid && in_grant;
         out_violation <= in_valid && !in_grant;
      end
   end

   // R4: every request yields a verdict in the next cycle
   a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R8: a verdict is either a grant or a violation, never both
   a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones({out_grant, out_violation}) == 1);

   // R10: no request means quiet outputs next cycle
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !out_grant && !out_violation);

endmodule

// File: rtl/frame_key_guard.sv
module frame_key_guard
   import fkg_pkg::*;
#(
   parameter int NUM_FRAMES    = 64,
   parameter int SW_W          = 64,
   parameter int KEY_POS       = 8,
   parameter bit MASTER_KEY_EN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          set_en,
   input  logic [$clog2(NUM_FRAMES)-1:0] set_frame,
   input  logic [3:0]                    set_acc,
   input  logic                          set_fguard,
   input  logic [$clog2(NUM_FRAMES)-1:0] ins_frame,
   output logic [3:0]                    ins_acc,
   output logic                          ins_fguard,
   input  logic                          req_valid,
   input  logic [$clog2(NUM_FRAMES)-1:0] req_frame,
   input  logic                          req_store,
   input  logic [SW_W-1:0]               req_status,
   output logic                          rsp_valid,
   output logic                          rsp_grant,
   output logic                          pgm_int_req
);

   localparam int FRAME_W = $clog2(NUM_FRAMES);
   localparam int KEY_HI  = SW_W - 1 - KEY_POS;

   if (NUM_FRAMES < 2 || (1 << FRAME_W) != NUM_FRAMES) begin : g_bad_frames
      $error("NUM_FRAMES must be a power of two of at least 2");
   end
   if (KEY_POS < 0 || KEY_POS + ACC_W > SW_W) begin : g_bad_keypos
      $error("key field must lie inside the status word");
   end

   frame_key_t         wr_key;
   frame_key_t         req_fkey;
   frame_key_t         ins_fkey;
   logic [ACC_W-1:0]   req_key;
   access_kind_t       kind;
   logic               grant_now;

   assign wr_key  = '{acc: set_acc, fguard: set_fguard};
   assign req_key = req_status[KEY_HI -: ACC_W];
   assign kind    = req_store ? KIND_STORE : KIND_FETCH;

   fkg_key_array #(.NUM_FRAMES(NUM_FRAMES)) u_keys (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (set_en),
      .wr_frame   (set_frame),
      .wr_key     (wr_key),
      .rd_a_frame (req_frame),
      .rd_a_key   (req_fkey),
      .rd_b_frame (ins_frame),
      .rd_b_key   (ins_fkey)
   );

   fkg_access_judge #(.MASTER_KEY_EN(MASTER_KEY_EN)) u_judge (
      .req_key (req_key),
      .kind    (kind),
      .fkey    (req_fkey),
      .grant   (grant_now)
   );

   fkg_resp_stage u_resp (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (req_valid),
      .in_grant      (grant_now),
      .out_valid     (rsp_valid),
      .out_grant     (rsp_grant),
      .out_violation (pgm_int_req)
   );

   assign ins_acc    = ins_fkey.acc;
   assign ins_fguard = ins_fkey.fguard;

   // R5: key zero is always granted
   a_r5_master_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (MASTER_KEY_EN && req_valid && req_key == '0) |=> rsp_grant);

   // R6: mismatched nonzero store is refused
   a_r6_store_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_store && req_key != '0 && req_key != req_fkey.acc)
      |=> pgm_int_req);

   // R7: fetch from an unguarded frame is granted
   a_r7_open_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_store && !req_fkey.fguard) |=> rsp_grant);

endmodule

// File: tb/frame_key_guard_test.sv
module frame_key_guard_test;

   localparam int CLK_PERIOD = 10;
   localparam int NF         = 64;
   localparam int FW         = 6;
   localparam int SWW        = 64;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           set_en = 1'b0;
   logic [FW-1:0]  set_frame = '0;
   logic [3:0]     set_acc = '0;
   logic           set_fguard = 1'b0;
   logic [FW-1:0]  ins_frame = '0;
   logic [3:0]     ins_acc;
   logic           ins_fguard;
   logic           req_valid = 1'b0;
   logic [FW-1:0]  req_frame = '0;
   logic           req_store = 1'b0;
   logic [SWW-1:0] req_status = '0;
   logic           rsp_valid;
   logic           rsp_grant;
   logic           pgm_int_req;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frame_key_guard #(.NUM_FRAMES(NF), .SW_W(SWW)) uut (
      .clk(clk), .rst_n(rst_n),
      .set_en(set_en), .set_frame(set_frame), .set_acc(set_acc), .set_fguard(set_fguard),
      .ins_frame(ins_frame), .ins_acc(ins_acc), .ins_fguard(ins_fguard),
      .req_valid(req_valid), .req_frame(req_frame), .req_store(req_store),
      .req_status(req_status),
      .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .pgm_int_req(pgm_int_req)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // key placed at positions 8..11 from the MSB: bits [55:52]
   function automatic logic [SWW-1:0] mkst(logic [3:0] key, logic [SWW-1:0] fill);
      logic [SWW-1:0] s = fill;
      s[55:52] = key;
      return s;
   endfunction

   task automatic set_key(int f, logic [3:0] acc, logic fg);
      @(negedge clk);
      set_en = 1'b1; set_frame = FW'(f); set_acc = acc; set_fguard = fg;
      @(negedge clk);
      set_en = 1'b0;
   endtask

   task automatic chk_ins(string tag, int f, logic [3:0] acc, logic fg);
      ins_frame = FW'(f);
      #1;
      chk(tag, {27'd0, ins_acc, ins_fguard}, {27'd0, acc, fg});
   endtask

   task automatic do_req(string tag, int f, logic st, logic [SWW-1:0] status, logic exp_grant);
      @(negedge clk);
      req_valid = 1'b1; req_frame = FW'(f); req_store = st; req_status = status;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
      chk({tag, " verdict"}, {30'd0, rsp_grant, pgm_int_req}, {30'd0, exp_grant, !exp_grant});
   endtask

   task automatic t_reset;
      chk("R1 outputs after reset", {29'd0, rsp_valid, rsp_grant, pgm_int_req}, 32'd0);
      chk_ins("R1 frame 0 key", 0, 4'd0, 1'b0);
      chk_ins("R1 frame 63 key", 63, 4'd0, 1'b0);
      do_req("R1 fetch key 6 to reset frame", 9, 1'b0, mkst(4'd6, '0), 1'b1);
   endtask

   task automatic t_set_insert;
      set_key(3, 4'd9, 1'b1);
      chk_ins("R2 written frame 3", 3, 4'd9, 1'b1);
      chk_ins("R2 neighbour frame 4 untouched", 4, 4'd0, 1'b0);
      chk_ins("R2 neighbour frame 2 untouched", 2, 4'd0, 1'b0);
   endtask

   task automatic t_store_rules;
      do_req("R6 store matching key", 3, 1'b1, mkst(4'd9, '0), 1'b1);
      do_req("R6 store mismatching key", 3, 1'b1, mkst(4'd8, '0), 1'b0);
      do_req("R5 store with key zero", 3, 1'b1, mkst(4'd0, '1), 1'b1);
   endtask

   task automatic t_fetch_rules;
      do_req("R7 guarded fetch mismatch", 3, 1'b0, mkst(4'd8, '0), 1'b0);
      do_req("R7 guarded fetch match", 3, 1'b0, mkst(4'd9, '0), 1'b1);
      set_key(10, 4'd2, 1'b0);
      do_req("R7 unguarded fetch mismatch", 10, 1'b0, mkst(4'd5, '0), 1'b1);
      do_req("R6 unguarded store mismatch", 10, 1'b1, mkst(4'd5, '0), 1'b0);
      do_req("R5 guarded fetch key zero", 3, 1'b0, mkst(4'd0, '0), 1'b1);
   endtask

   task automatic t_key_field;
      do_req("R3 key 9 among ones", 3, 1'b1, mkst(4'd9, '1), 1'b1);
      do_req("R3 key 1 among ones", 3, 1'b1, mkst(4'd1, '1), 1'b0);
      do_req("R3 msb of key field", 3, 1'b1, mkst(4'd9, 64'h0), 1'b1);
      do_req("R3 key zero with ones around", 3, 1'b1, mkst(4'd0, 64'hFFF0_FFFF_FFFF_FFFF), 1'b1);
   endtask

   task automatic t_same_cycle;
      set_key(5, 4'd7, 1'b1);
      @(negedge clk);
      set_en = 1'b1; set_frame = FW'(5); set_acc = 4'd3; set_fguard = 1'b1;
      req_valid = 1'b1; req_frame = FW'(5); req_store = 1'b1; req_status = mkst(4'd3, '0);
      @(negedge clk);
      set_en = 1'b0; req_valid = 1'b0;
      chk("R9 same-cycle request uses old key", {30'd0, rsp_grant, pgm_int_req}, 32'd1);
      do_req("R9 next request uses new key", 5, 1'b1, mkst(4'd3, '0), 1'b1);
   endtask

   task automatic t_back_to_back;
      @(negedge clk);
      req_valid = 1'b1; req_frame = FW'(3); req_store = 1'b1; req_status = mkst(4'd9, '0);
      @(negedge clk);
      chk("R4 first of pair", {29'd0, rsp_valid, rsp_grant, pgm_int_req}, 32'b110);
      req_frame = FW'(3); req_store = 1'b0; req_status = mkst(4'd4, '0);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R4 second of pair", {29'd0, rsp_valid, rsp_grant, pgm_int_req}, 32'b101);
      chk("R8 second verdict is a violation", {31'd0, pgm_int_req}, 32'd1);
   endtask

   task automatic t_idle;
      @(negedge clk);
      chk("R10 idle cycle quiet", {29'd0, rsp_valid, rsp_grant, pgm_int_req}, 32'd0);
      @(negedge clk);
      chk("R10 second idle cycle quiet", {29'd0, rsp_valid, rsp_grant, pgm_int_req}, 32'd0);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_insert();
      t_store_rules();
      t_fetch_rules();
      t_key_field();
      t_same_cycle();
      t_back_to_back();
      t_idle();
      finish_run();
   end

endmodule